// File: doc/BRIEF.md
# Repeated String Copy Engine

This block is a hardware sequencer that carries out a whole repeated byte-move as one operation. Three registers hold the operation's state: a source pointer, a destination pointer and a byte count. Software-facing logic loads all three with one strobe and then pulses a start input. The engine then moves the string one byte at a time from increasing source addresses to increasing destination addresses. Forward copying is the only direction it supports. It does this over a byte-wide memory that has a separate read port and a separate write port.

The three registers stay visible on output pins at all times. They advance with every byte moved. When the operation finishes, both pointers hold the address one past the last byte moved and the count holds zero. A `busy` flag covers the whole operation, and `done` pulses for one cycle at its end.

Both memory ports use valid/ready handshakes, so the memory can stall the engine at any point:
- **Read request:** a request sits on `rd_req_valid` with `rd_addr` until the memory raises `rd_req_ready`.
- **Read data:** the data returns on `rd_rsp_valid`. The engine takes it only while `rd_rsp_ready` is high, and the memory must hold the data until then.
- **Write:** a write sits on `wr_valid` with `wr_addr` and `wr_data` until `wr_ready` is high.

The engine keeps at most one byte in flight.

Top module: `string_copy_engine`

## Requirements
- R1: While `busy` is low, a cycle with `load` high writes `load_src`, `load_dst` and `load_cnt` into the source pointer, destination pointer and count, which appear on `src_ptr`, `dst_ptr` and `count` after that clock edge.
- R2: For each byte, the engine reads the byte at the address on `src_ptr` and writes that same value to the address on `dst_ptr`. Bytes go in ascending address order on both ports.
- R3: Each accepted write (`wr_valid` and `wr_ready` both high) increments `src_ptr` and `dst_ptr` by 1 and decrements `count` by 1 at that clock edge.
- R4: The operation ends when the count reaches zero. Exactly `load_cnt` reads and `load_cnt` writes occur. `done` is high for exactly one cycle, and in that cycle `count` is zero and each pointer equals its loaded value plus the loaded count. Bytes outside the destination range are unchanged.
- R5: A start while the count is zero makes no read and no write, and `done` is high in the cycle after the start edge.
- R6: `busy` is high from the cycle after an accepted start through the cycle in which `done` is high, and is low otherwise.
- R7: While `busy` is high, `start` and `load` have no effect: the register values at completion are the same as with no such pulse.
- R8: Read back-pressure: once `rd_req_valid` rises, it stays high with `rd_addr` unchanged until a cycle with `rd_req_ready` high. `rd_rsp_data` is taken only in a cycle where `rd_rsp_valid` and `rd_rsp_ready` are both high.
- R9: Write back-pressure: once `wr_valid` rises, it stays high with `wr_addr` and `wr_data` unchanged until a cycle with `wr_ready` high. No next read is issued before that write is accepted.
- R10: After reset, `busy`, `done`, `rd_req_valid`, `rd_rsp_ready` and `wr_valid` are low, and `src_ptr`, `dst_ptr` and `count` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Load the three registers from the load_* inputs (ignored while busy) |
| load_src | input | 16 | Source pointer value to load |
| load_dst | input | 16 | Destination pointer value to load |
| load_cnt | input | 16 | Byte count to load |
| start | input | 1 | Begin the copy (ignored while busy) |
| src_ptr | output | 16 | Current source pointer |
| dst_ptr | output | 16 | Current destination pointer |
| count | output | 16 | Bytes still to move |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Memory accepts the read request |
| rd_addr | output | 16 | Read address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_ready | output | 1 | Engine can take read data |
| rd_rsp_data | input | 8 | Read data byte |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | 16 | Write address |
| wr_data | output | 8 | Write data byte |

## Verification
The copy is run over several string lengths and under several memory behaviours:
- **Single byte:** a one-byte copy separates the termination on a count of one from the loop-back path taken for longer strings.
- **Memory stalls:** separate runs stall only the read request, delay only the read response by a fixed amount, stall only the write, or stall all three at random. Each exposes a different handshake that could drop, repeat or reorder a byte.
- **Termination:** after each copy, the bench compares the bytes just past the end and just before the start of the destination with their initial values, to catch overrun and underrun.
- **Zero count and busy pulses:** a zero-count start and a second start with no reload show that no memory access occurs when the count is zero. Load and start pulses injected mid-copy must leave the final register values unchanged.

// File: rtl/copy_pkg.sv
package copy_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD_REQ  = 3'd1,
    ST_RD_WAIT = 3'd2,
    ST_WRITE   = 3'd3,
    ST_FIN     = 3'd4
  } copy_state_e;

endpackage

// File: rtl/copy_arch_regs.sv
module copy_arch_regs #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_src,
  input  logic [ADDR_W-1:0] load_dst,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic              step,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              cnt_is_zero,
  output logic              cnt_is_one
);

  localparam logic [ADDR_W-1:0] PTR_INC = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  CNT_DEC = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
    end else if (load_en) begin
      src_q <= load_src;
      dst_q <= load_dst;
      cnt_q <= load_cnt;
    end else if (step) begin
      src_q <= src_q + PTR_INC;
      dst_q <= dst_q + PTR_INC;
      cnt_q <= cnt_q - CNT_DEC;
    end
  end

  assign cnt_is_zero = (cnt_q == '0);
  assign cnt_is_one  = (cnt_q == CNT_DEC);

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (src_q == $past(src_q) + PTR_INC) && (dst_q == $past(dst_q) + PTR_INC)
             && (cnt_q == $past(cnt_q) - CNT_DEC)); // R3

endmodule

// File: rtl/copy_seq_fsm.sv
module copy_seq_fsm
  import copy_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cnt_is_zero,
  input  logic              cnt_is_one,
  input  logic              rd_req_ready,
  input  logic              rd_rsp_valid,
  input  logic [DATA_W-1:0] rd_rsp_data,
  input  logic              wr_ready,
  output logic              busy,
  output logic              done,
  output logic              step,
  output logic              rd_req_valid,
  output logic              rd_rsp_ready,
  output logic              wr_valid,
  output logic [DATA_W-1:0] wr_data
);

  copy_state_e state;
  logic [DATA_W-1:0] byte_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      byte_q <= '0;
    end else begin
      case (state)
        ST_IDLE:    if (start) state <= cnt_is_zero ? ST_FIN : ST_RD_REQ;
        ST_RD_REQ:  if (rd_req_ready) state <= ST_RD_WAIT;
        ST_RD_WAIT: if (rd_rsp_valid) begin
                      byte_q <= rd_rsp_data;
                      state  <= ST_WRITE;
                    end
        ST_WRITE:   if (wr_ready) state <= cnt_is_one ? ST_FIN : ST_RD_REQ;
        ST_FIN:     state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy         = (state != ST_IDLE);
    done         = (state == ST_FIN);
    rd_req_valid = (state == ST_RD_REQ);
    rd_rsp_ready = (state == ST_RD_WAIT);
    wr_valid     = (state == ST_WRITE);
    step         = (state == ST_WRITE) && wr_ready;
    wr_data      = byte_q;
  end

  AST_ZERO_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && cnt_is_zero) |=> (done && !rd_req_valid && !wr_valid)); // R5

  AST_RD_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> rd_req_valid); // R8

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data))); // R9

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R6

endmodule

// File: rtl/string_copy_engine.sv
module string_copy_engine #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_src,
  input  logic [ADDR_W-1:0] load_dst,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic              start,
  output logic [ADDR_W-1:0] src_ptr,
  output logic [ADDR_W-1:0] dst_ptr,
  output logic [CNT_W-1:0]  count,
  output logic              busy,
  output logic              done,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [DATA_W-1:0] rd_rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  logic load_en;
  logic step;
  logic cnt_is_zero;
  logic cnt_is_one;

  assign load_en = load && !busy;

  copy_arch_regs #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_en     (load_en),
    .load_src    (load_src),
    .load_dst    (load_dst),
    .load_cnt    (load_cnt),
    .step        (step),
    .src_q       (src_ptr),
    .dst_q       (dst_ptr),
    .cnt_q       (count),
    .cnt_is_zero (cnt_is_zero),
    .cnt_is_one  (cnt_is_one)
  );

  copy_seq_fsm #(
    .DATA_W (DATA_W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .cnt_is_zero  (cnt_is_zero),
    .cnt_is_one   (cnt_is_one),
    .rd_req_ready (rd_req_ready),
    .rd_rsp_valid (rd_rsp_valid),
    .rd_rsp_data  (rd_rsp_data),
    .wr_ready     (wr_ready),
    .busy         (busy),
    .done         (done),
    .step         (step),
    .rd_req_valid (rd_req_valid),
    .rd_rsp_ready (rd_rsp_ready),
    .wr_valid     (wr_valid),
    .wr_data      (wr_data)
  );

  assign rd_addr = src_ptr;
  assign wr_addr = dst_ptr;

  AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (count == '0)); // R4

  AST_RD_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> $stable(rd_addr)); // R8

  AST_WR_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> $stable(wr_addr)); // R9

  AST_BUSY_BLOCKS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step) |=> ($stable(src_ptr) && $stable(count))); // R7

endmodule

// File: tb/test_string_copy_engine.sv
`timescale 1ns/1ps
module test_string_copy_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [15:0] load_src = '0, load_dst = '0, load_cnt = '0;
  logic        start = 1'b0;
  logic [15:0] src_ptr, dst_ptr, count;
  logic        busy, done;
  logic        rd_req_valid, rd_req_ready;
  logic [15:0] rd_addr;
  logic        rd_rsp_valid, rd_rsp_ready;
  logic [7:0]  rd_rsp_data;
  logic        wr_valid, wr_ready;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;

  always #2.5 clk = ~clk;

  string_copy_engine i_string_copy_engine (
    .clk(clk), .rst_n(rst_n), .load(load), .load_src(load_src), .load_dst(load_dst),
    .load_cnt(load_cnt), .start(start), .src_ptr(src_ptr), .dst_ptr(dst_ptr),
    .count(count), .busy(busy), .done(done), .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready), .rd_addr(rd_addr), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int errors = 0;
  int checks = 0;

  // memory model state
  logic [7:0]  mem [0:1023];
  int          mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  int          rd_hs = 0, wr_hs = 0, order_err = 0, hold_err = 0;
  logic [15:0] exp_ra = '0, exp_wa = '0;
  logic        pend = 1'b0;
  logic [15:0] pend_addr = '0;
  int          lat_cnt = 0;
  logic        p_rdv = 1'b0, p_rsp_rdy = 1'b0, p_wrv = 1'b0;
  logic [15:0] p_rda = '0, p_wra = '0;
  logic [7:0]  p_wrd = '0;

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 29 + 5) ^ (i >> 3));
  endfunction

  task automatic init_mem();
    for (int i = 0; i < 1024; i++) mem[i] = pat(i);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // memory model, acts at the falling edge only
  always @(negedge clk) begin
    if (!rst_n) begin
      rd_req_ready = 1'b0; rd_rsp_valid = 1'b0; rd_rsp_data = '0; wr_ready = 1'b0;
      pend = 1'b0; p_rdv = 1'b0; p_rsp_rdy = 1'b0; p_wrv = 1'b0;
    end else begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      // handshakes completed at the previous rising edge
      if (p_rdv && rd_req_ready) begin
        if (p_rda != exp_ra) order_err++;
        exp_ra = exp_ra + 16'd1;
        rd_hs++;
        pend = 1'b1; pend_addr = p_rda;
        lat_cnt = (mode == 2) ? 2 : (mode == 4) ? int'(lfsr[1:0]) : 0;
      end
      if (rd_rsp_valid && p_rsp_rdy) rd_rsp_valid = 1'b0;
      if (p_wrv && wr_ready) begin
        if (p_wra != exp_wa) order_err++;
        exp_wa = exp_wa + 16'd1;
        wr_hs++;
        mem[p_wra[9:0]] = p_wrd;
      end
      // R9/R8 hold checks across a stalled edge
      if (p_wrv && !wr_ready && (!wr_valid || wr_addr != p_wra || wr_data != p_wrd)) hold_err++;
      if (p_rdv && !rd_req_ready && (!rd_req_valid || rd_addr != p_rda)) hold_err++;
      // new drives
      rd_req_ready = (mode == 1 || mode == 4) ? lfsr[3] : 1'b1;
      wr_ready     = (mode == 3 || mode == 4) ? lfsr[5] : 1'b1;
      if (pend && !rd_rsp_valid) begin
        if (lat_cnt == 0) begin
          rd_rsp_valid = 1'b1; rd_rsp_data = mem[pend_addr[9:0]]; pend = 1'b0;
        end else lat_cnt--;
      end
      p_rdv = rd_req_valid; p_rda = rd_addr; p_rsp_rdy = rd_rsp_ready;
      p_wrv = wr_valid; p_wra = wr_addr; p_wrd = wr_data;
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic run_copy(input int s, input int d, input int n, input int m, input bit poke);
    int waited;
    int bad;
    init_mem();
    mode = m;
    tick();
    load = 1'b1; load_src = 16'(s); load_dst = 16'(d); load_cnt = 16'(n);
    tick();
    load = 1'b0;
    chk(src_ptr == 16'(s) && dst_ptr == 16'(d) && count == 16'(n), "R1", "loaded regs",
        count, n);
    rd_hs = 0; wr_hs = 0; order_err = 0; hold_err = 0;
    exp_ra = 16'(s); exp_wa = 16'(d);
    start = 1'b1;
    tick();
    start = 1'b0;
    chk(busy == 1'b1, "R6", "busy after start", busy, 1);
    if (poke) begin
      tick(); tick();
      load = 1'b1; start = 1'b1; load_src = 16'h0333; load_dst = 16'h0111; load_cnt = 16'd3;
      tick();
      load = 1'b0; start = 1'b0;
    end
    waited = 0;
    while (!done && waited < 20000) begin tick(); waited++; end
    chk(done == 1'b1, "R4", "done reached", done, 1);
    chk(src_ptr == 16'(s + n) && dst_ptr == 16'(d + n) && count == 16'd0,
        poke ? "R7" : "R4", "final pointers", src_ptr, s + n);
    tick();
    chk(!done && !busy, "R6", "done one cycle then idle", {busy, done}, 0);
    tick();
    chk(rd_hs == n && wr_hs == n, "R4", "access counts", wr_hs, n);
    chk(order_err == 0, "R2", "ascending order", order_err, 0);
    chk(hold_err == 0, (m == 3) ? "R9" : "R8", "held under stall", hold_err, 0);
    bad = 0;
    for (int k = 0; k < n; k++) if (mem[(d + k) % 1024] != pat(s + k)) bad++;
    chk(bad == 0, "R2", "copied bytes", bad, 0);
    chk(mem[(d + n) % 1024] == pat(d + n) && mem[(d + 1023) % 1024] == pat((d + 1023) % 1024),
        "R4", "neighbours untouched", mem[(d + n) % 1024], pat(d + n));
  endtask

  // {src, dst, count, mode}: mode 0 none, 1 read-req stall, 2 response delay,
  // 3 write stall, 4 all random
  localparam logic [51:0] VEC [6] = '{
    {16'h0010, 16'h0200, 16'd1,  4'd0},
    {16'h0040, 16'h0280, 16'd5,  4'd1},
    {16'h0003, 16'h0301, 16'd17, 4'd2},
    {16'h0100, 16'h0000, 16'd12, 4'd3},
    {16'h00A0, 16'h0380, 16'd40, 4'd4},
    {16'h0150, 16'h01F0, 16'd32, 4'd4}
  };

  initial begin
    init_mem();
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R10 reset state
    chk(!busy && !done && !rd_req_valid && !rd_rsp_ready && !wr_valid, "R10", "reset flags",
        {busy, done, rd_req_valid, rd_rsp_ready, wr_valid}, 0);
    chk(src_ptr == 0 && dst_ptr == 0 && count == 0, "R10", "reset regs", count, 0);

    for (int v = 0; v < 6; v++)
      run_copy(int'(VEC[v][51:36]), int'(VEC[v][35:20]), int'(VEC[v][19:4]),
               int'(VEC[v][3:0]), 1'b0);

    // R5: start again without reload, count already zero
    rd_hs = 0; wr_hs = 0;
    start = 1'b1;
    tick();
    start = 1'b0;
    chk(done && busy, "R5", "done next cycle on zero count", {busy, done}, 3);
    tick();
    chk(!done && !busy, "R5", "idle after zero-count done", {busy, done}, 0);
    tick(); tick();
    chk(rd_hs == 0 && wr_hs == 0 && !rd_req_valid, "R5", "no access on zero count", rd_hs, 0);

    // R7: load and start pulses during a stalled copy
    run_copy(16'h0020, 16'h0240, 8, 3, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule